// File: doc/BRIEF.md
# Character-Row Screen Address Generator

This block supplies the byte address for display fetches from a screen memory organised in character cells. Eight consecutive bytes hold the eight pixel lines of one cell column. Moving one byte to the right along a scanline therefore means stepping the address by 8. The next scanline of the same character row starts one byte after the start of the previous scanline. When a row of eight lines is finished, the address is pulled back by 7, which lands on the first byte of the next row.

The screen always ends at the top of the lower 32 KiB (address 0x8000). Its start depends on the display mode: the start is 0x8000 minus the bytes the mode needs, rounded down to a 256-byte boundary. Any address that reaches 0x8000 is folded back by the screen size. Modes with 25 character rows leave two blank gap lines after every row and a long blank footer after the last row. While a gap runs, the block raises a flag and holds its address.

A display fetcher drives the block with three single-cycle strobes:
- a frame strobe, which also picks up a new mode,
- a line-end strobe for each active scanline,
- a fetch strobe for every byte it reads.

Top module: `crg_addr_gen`

## Requirements
- R1: Each mode number sets a layout. The layouts are:

  | Mode number | Bytes per line | Rows | Screen start |
  |---|---|---|---|
  | 0, 1, 2 | 80 | 32 | 0x3000 |
  | 3 | 80 | 25 | 0x4100 |
  | 4, 5 | 40 | 32 | 0x5800 |
  | 6 and the unused code 7 | 40 | 25 | 0x6000 |

  In every mode the screen size is 0x8000 minus the start.
- R2: `fetch_addr` never leaves the range from the active screen start up to 0x7FFF. A step that reaches 0x8000 or more has the screen size subtracted from it.
- R3: A `fetch_adv` pulse adds 8 to the address. The wrap rule of R2 then applies.
- R4: A `line_end` pulse outside a gap increments a line counter. If the new count is not a multiple of 8, the address becomes the saved line start plus 1.
- R5: A `line_end` pulse that brings the line counter to a multiple of 8 subtracts 7 from the current address, so the address moves to the first byte of the next character row.
- R6: In a 25-row mode, `gap_active` rises after each completed character row. Exactly two further `line_end` pulses clear it.
- R7: While `gap_active` is high, `fetch_adv` and `line_end` do not change `fetch_addr`.
- R8: In a 25-row mode, completing line 200 (the last character row) starts a footer gap of 64 lines in place of the two-line gap.
- R9: A `frame_start` pulse loads the address with the screen start of the mode on `mode_sel`, clears the gap and the line counter, and overrides `line_end` and `fetch_adv` in the same cycle. `line_end` overrides `fetch_adv`.
- R10: `mode_sel` takes effect only on a `frame_start` pulse. Between frame pulses, the layout latched at the last frame pulse stays in use.
- R11: Reset is synchronous and active low. After reset the address is 0x6000 (layout of mode 6) and `gap_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 3 | Requested display mode, sampled on `frame_start` |
| frame_start | input | 1 | One-cycle pulse at the top of each frame |
| line_end | input | 1 | One-cycle pulse at the end of each active scanline |
| fetch_adv | input | 1 | One-cycle pulse per display byte fetched |
| fetch_addr | output | 16 | Byte address of the next display fetch |
| gap_active | output | 1 | High while blank gap or footer lines are being counted |

## Verification
The assertions check the following properties on every cycle:
- the address stays inside the active screen window;
- a plain fetch step moves the address by exactly 8, or by 8 less the screen size;
- a gap freezes the address;
- a frame pulse reloads the screen start and clears the gap;
- the latched mode stays unchanged between frame pulses.

Some properties need whole sequences of strobes, so only the bench scenarios can show them:
- the +1 and −7 stepping over a full character row;
- the exact gap length of two lines;
- the 64-line footer after line 200;
- the fold at the top of memory;
- the fact that a mode request made mid-frame waits for the next frame.

// File: rtl/crg_pkg.sv
// Package: shared constants, layout record and the elaboration-time layout
// calculation for the character-row address generator.
// Assumes the screen always ends at SCREEN_TOP and cells are CELL_LINES tall.
package crg_pkg;

    localparam int ADDR_W        = 16;
    localparam int MODE_W        = 3;
    localparam int NUM_MODES     = 1 << MODE_W;
    localparam int CELL_LINES    = 8;
    localparam int SCREEN_TOP    = 32'h8000;
    localparam int DISPLAY_LINES = 256;
    localparam int FRAME_LINES   = 312;
    localparam int LINE_W        = 9;
    localparam int GAP_W         = 8;
    localparam int ALIGN_MASK    = 32'hFF00;

    // Per-mode layout needed by the address stepping and gap logic.
    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] size;
        logic [GAP_W-1:0]  spacing;
        logic [LINE_W-1:0] last_line;
        logic [GAP_W-1:0]  margin;
    } layout_t;

    // Derives one mode's layout from its pixel width, depth and row count.
    function automatic layout_t calc_layout(input int m);
        int w, d, r, line_bytes, row_bytes, total, start, spacing, margin;
        layout_t l;
        case (m)
            0:       begin w = 640; d = 1; r = 32; end
            1:       begin w = 320; d = 2; r = 32; end
            2:       begin w = 160; d = 4; r = 32; end
            3:       begin w = 640; d = 1; r = 25; end
            4:       begin w = 320; d = 1; r = 32; end
            5:       begin w = 160; d = 2; r = 32; end
            default: begin w = 320; d = 1; r = 25; end
        endcase
        line_bytes  = (w * d) / 8;
        row_bytes   = line_bytes * CELL_LINES;
        total       = row_bytes * r;
        start       = (SCREEN_TOP - total) & ALIGN_MASK;
        spacing     = DISPLAY_LINES / r - CELL_LINES;
        margin      = FRAME_LINES - r * (CELL_LINES + spacing) + spacing;
        l.start     = ADDR_W'(start);
        l.size      = ADDR_W'(SCREEN_TOP - start);
        l.spacing   = GAP_W'(spacing);
        l.last_line = LINE_W'(r * CELL_LINES);
        l.margin    = GAP_W'(margin);
        return l;
    endfunction

endpackage

// File: rtl/crg_mode_table.sv
// Mode table: returns the layout record for a mode number.
// Assumes every code of MODE_W bits is legal; the table is built at
// elaboration from calc_layout, so it synthesizes to a constant mux.
module crg_mode_table
    import crg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output layout_t           layout
);

    layout_t tbl [NUM_MODES];

    // One constant entry per mode code.
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        assign tbl[g] = calc_layout(g);
    end

    // Select the entry for the requested mode.
    assign layout = tbl[mode];

endmodule

// File: rtl/crg_wrap.sv
// Wrap unit: folds a candidate address back into the screen window.
// Assumes the candidate is below top + size, so one subtraction is enough.
module crg_wrap #(
    parameter int AW  = 16,
    parameter int TOP = 32'h8000
) (
    input  logic [AW-1:0] cand,
    input  logic [AW-1:0] size,
    output logic [AW-1:0] wrapped
);

    localparam logic [AW-1:0] TOP_V = AW'(TOP);

    // Subtract the screen size when the candidate reaches the top.
    always_comb begin
        if (cand >= TOP_V) wrapped = cand - size;
        else               wrapped = cand;
    end

endmodule

// File: rtl/crg_gap_ctrl.sv
// Gap counter: counts the remaining blank lines between character rows and
// in the footer. A load happens only when the count is zero; a frame pulse
// clears it; each line end while non-zero takes one off.
module crg_gap_ctrl #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_end,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    output logic          active
);

    logic [GW-1:0] cnt_q;

    // Counter update with frame clear as the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (line_end && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R6: a line end inside a gap shortens it by exactly one line.
    assert_gap_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && active && !frame_start && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/crg_addr_gen.sv
// Character-row screen address generator (top).
// Steps the display fetch address by 8 per byte, by +1 from the saved line
// start per scanline and by -7 at each row boundary, folds it at the top of
// screen memory and runs the gap lines of 25-row modes.
// Assumes one-cycle strobes; priority frame_start > line_end > fetch_adv.
module crg_addr_gen
    import crg_pkg::*;
#(
    parameter int RESET_MODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              fetch_adv,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              gap_active
);

    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(CELL_LINES);
    localparam logic [ADDR_W-1:0] STEP_BACK = ADDR_W'(CELL_LINES - 1);
    localparam int                CELL_BITS = $clog2(CELL_LINES);
    localparam logic [MODE_W-1:0] RST_MODE  = MODE_W'(RESET_MODE);
    localparam layout_t           RST_LAY   = calc_layout(RESET_MODE);

    logic [MODE_W-1:0] mode_q;
    logic [ADDR_W-1:0] addr_q, lstart_q, cand, wrapped;
    logic [LINE_W-1:0] line_q, line_inc;
    layout_t           lay_now, lay_next;
    logic              row_done, footer_hit, gap_load, line_step;
    logic [GAP_W-1:0]  gap_val;

    crg_mode_table u_now  (.mode(mode_q),   .layout(lay_now));
    crg_mode_table u_next (.mode(mode_sel), .layout(lay_next));

    // Line stepping decisions for the current scanline end.
    always_comb begin
        line_inc   = line_q + 1'b1;
        line_step  = line_end && !gap_active;
        row_done   = line_step && (line_inc[CELL_BITS-1:0] == '0);
        footer_hit = row_done && (lay_now.spacing != '0) && (line_inc == lay_now.last_line);
        gap_load   = row_done && (lay_now.spacing != '0);
        gap_val    = footer_hit ? lay_now.margin : lay_now.spacing;
    end

    // Candidate next address before folding.
    always_comb begin
        if (line_end)      cand = row_done ? (addr_q - STEP_BACK) : (lstart_q + 1'b1);
        else               cand = addr_q + STEP_BYTE;
    end

    crg_wrap #(.AW(ADDR_W), .TOP(SCREEN_TOP)) u_wrap (
        .cand(cand), .size(lay_now.size), .wrapped(wrapped));

    crg_gap_ctrl #(.GW(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .load(gap_load && !frame_start), .load_val(gap_val), .active(gap_active));

    // Latch the mode only at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= RST_MODE;
        else if (frame_start) mode_q <= mode_sel;
    end

    // Address, line start and line counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= RST_LAY.start;
            lstart_q <= RST_LAY.start;
            line_q   <= '0;
        end else if (frame_start) begin
            addr_q   <= lay_next.start;
            lstart_q <= lay_next.start;
            line_q   <= '0;
        end else if (line_step) begin
            addr_q   <= wrapped;
            line_q   <= line_inc;
            if (!footer_hit) lstart_q <= wrapped;
        end else if (fetch_adv && !line_end && !gap_active) begin
            addr_q   <= wrapped;
        end
    end

    assign fetch_addr = addr_q;

    // R2: address always inside the active screen window.
    assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr < ADDR_W'(SCREEN_TOP)) && (fetch_addr >= lay_now.start));

    // R3: a plain fetch step moves by 8, or by 8 less the screen size.
    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv && !line_end && !frame_start && !gap_active) |=>
        ((fetch_addr - $past(fetch_addr)) == STEP_BYTE) ||
        (($past(fetch_addr) + STEP_BYTE - fetch_addr) == lay_now.size));

    // R7: address frozen while a gap runs.
    assert_gap_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_active && !frame_start) |=> $stable(fetch_addr));

    // R9: frame pulse reloads the requested start and clears the gap.
    assert_frame_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fetch_addr == $past(lay_next.start)) && !gap_active);

    // R10: the latched mode holds between frame pulses.
    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode_q));

endmodule

// File: tb/sim_crg_addr_gen.sv
module sim_crg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        frame_start = 1'b0, line_end = 1'b0, fetch_adv = 1'b0;
    logic [15:0] fetch_addr;
    logic        gap_active;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    crg_addr_gen u0 (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_start(frame_start),
        .line_end(line_end), .fetch_adv(fetch_adv), .fetch_addr(fetch_addr), .gap_active(gap_active));

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic frame(input int m);
        @(negedge clk); mode_sel = 3'(m); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic adv(input int n);
        if (n > 0) begin
            @(negedge clk); fetch_adv = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk); fetch_adv = 1'b0;
        end
    endtask

    task automatic lend();
        @(negedge clk); line_end = 1'b1;
        @(negedge clk); line_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset addr", fetch_addr, 16'h6000);
        chk("R11 reset gap", gap_active, 0);
    endtask

    task automatic t_starts();
        int exp_s [8] = '{16'h3000, 16'h3000, 16'h3000, 16'h4100, 16'h5800, 16'h5800, 16'h6000, 16'h6000};
        for (int m = 0; m < 8; m++) begin
            frame(m);
            chk($sformatf("R1 start mode %0d", m), fetch_addr, exp_s[m]);
        end
    endtask

    task automatic t_row_steps();
        frame(0);
        adv(3);
        chk("R3 three fetches", fetch_addr, 16'h3018);
        adv(77);
        lend();
        chk("R4 next line start", fetch_addr, 16'h3001);
        for (int l = 1; l < 7; l++) begin adv(80); lend(); end
        chk("R4 line 7 start", fetch_addr, 16'h3007);
        adv(80);
        chk("R3 end of line 7", fetch_addr, 16'h3287);
        lend();
        chk("R5 next row", fetch_addr, 16'h3280);
        chk("R5 no gap in 32-row mode", gap_active, 0);
    endtask

    task automatic t_wrap();
        frame(4);
        adv(1279);
        chk("R2 last before top", fetch_addr, 16'h7FF8);
        adv(1);
        chk("R2 folded to start", fetch_addr, 16'h5800);
    endtask

    task automatic t_gap();
        frame(6);
        for (int l = 0; l < 8; l++) begin adv(40); lend(); end
        chk("R6 gap after row", gap_active, 1);
        chk("R5 row 1 start", fetch_addr, 16'h6140);
        adv(5);
        chk("R7 fetch ignored in gap", fetch_addr, 16'h6140);
        lend();
        chk("R6 gap after one line", gap_active, 1);
        chk("R7 line end frozen", fetch_addr, 16'h6140);
        lend();
        chk("R6 gap over after two", gap_active, 0);
        adv(40); lend();
        chk("R4 first line of row 1", fetch_addr, 16'h6141);
    endtask

    task automatic t_footer();
        frame(6);
        for (int r = 0; r < 25; r++) begin
            for (int l = 0; l < 8; l++) begin adv(40); lend(); end
            if (r < 24) begin lend(); lend(); end
        end
        chk("R8 address after last row", fetch_addr, 16'h7F40);
        chk("R8 footer gap starts", gap_active, 1);
        repeat (63) lend();
        chk("R8 footer still running at 63", gap_active, 1);
        lend();
        chk("R8 footer over at 64", gap_active, 0);
    endtask

    task automatic t_priority_mode();
        frame(6);
        mode_sel = 3'd0;
        for (int l = 0; l < 8; l++) begin adv(40); lend(); end
        chk("R10 old layout kept mid-frame", gap_active, 1);
        chk("R10 old stride kept", fetch_addr, 16'h6140);
        @(negedge clk); frame_start = 1'b1; line_end = 1'b1; fetch_adv = 1'b1;
        @(negedge clk); frame_start = 1'b0; line_end = 1'b0; fetch_adv = 1'b0;
        chk("R9 frame wins and loads new mode", fetch_addr, 16'h3000);
        chk("R9 gap cleared", gap_active, 0);
        adv(4);
        @(negedge clk); line_end = 1'b1; fetch_adv = 1'b1;
        @(negedge clk); line_end = 1'b0; fetch_adv = 1'b0;
        chk("R9 line end wins over fetch", fetch_addr, 16'h3001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_starts();
        t_row_steps();
        t_wrap();
        t_gap();
        t_footer();
        t_priority_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule